// File: doc/BRIEF.md
# Four-Mode Timer/Counter

This block is a byte-wide timer/counter of the kind found beside a small 8-bit processor core. Two 8-bit count registers, a low one and a high one, are arranged by a two-bit mode field into one of four structures: a 13-bit count formed from a 5-bit prescaler feeding an 8-bit counter, a plain 16-bit count, an 8-bit count that reloads itself from the high register, or two independent 8-bit counters. A rollover of the counting structure sets an overflow flag, and that flag drives the interrupt request.

The low path advances on one of two sources. The first is the timer clock, which is either a peripheral tick or every second cycle of the block clock. The second is a falling edge on an external event pin. Counting is enabled by a run bit. A gate bit can also make counting depend on an external interrupt pin. In the split structure the high counter runs from a run bit owned by a neighbouring timer and reports its own rollovers back to that neighbour through a pulse.

Software reaches the block through a small register port, with a write channel and a combinational read channel. An interrupt-acknowledge input clears the flag without a register write.

Top module: `tmr_quad`

## Requirements
- R1: After reset both count registers, the control field, the run bit, the overflow flag, `irq` and `hi_ovf_set` read as zero.
- R2: Mode 00 (13-bit): each low-path event increments low bits [4:0] modulo 32. When those bits wrap from 31, the high register increments. A wrap of both from all ones sets the flag. Low bits [7:5] are never changed by counting and do not affect it.
- R3: Mode 01 (16-bit): each low-path event increments {high, low} as one 16-bit value. The wrap from 0xFFFF to 0 sets the flag.
- R4: Mode 10 (auto-reload): each low-path event increments the low register. A low-path event at 0xFF loads the low register from the high register and sets the flag. The high register is changed only by writes.
- R5: Mode 11 (split): the low register is an 8-bit counter on the low path and sets the flag at its 0xFF wrap. The high register counts timer-clock ticks while `hi_run_in` is 1, regardless of the run bit, gate or source select. `hi_ovf_set` is 1 in the cycle in which a high-register count wraps 0xFF to 0.
- R6: The flag is written by a flag-register write. Otherwise an overflow sets it. Otherwise `irq_ack` clears it. `irq` equals the flag.
- R7: The low path counts only while the run bit is 1. With control bit 3 (gate) at 1 it also needs `gate_pin` at 1, as seen through a two-flop synchronizer.
- R8: With `clk_sel`=1 the timer clock is `periph_tick`. With `clk_sel`=0 the timer clock is 1 on every second `clk` cycle, starting with the second cycle after reset release.
- R9: With control bit 2 (source) at 1, the low path counts a 1-to-0 transition of `ev_pin`. The pin is synchronized by two flops and compared with its value at the previous timer-clock tick, so a transition is detected only on a tick.
- R10: A write to address 0 or 1 in a cycle cancels all counting in that cycle, in both paths, and the written value is loaded.
- R11: Register map by `wr_sel`/`rd_sel`: 0 = low count, 1 = high count, 2 = control (bit 3 gate, bit 2 source select, bits 1:0 mode, bits 7:4 read zero), 3 = flags (bit 0 run, bit 1 overflow, bits 7:2 read zero). Values written read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_sel | input | 1 | Timer clock select: 1 peripheral tick, 0 half rate of `clk` |
| periph_tick | input | 1 | Peripheral clock tick enable |
| ev_pin | input | 1 | External event input, asynchronous |
| gate_pin | input | 1 | External gate (interrupt) pin, asynchronous, active high |
| hi_run_in | input | 1 | Neighbour timer run bit, used by the high counter in split mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_sel | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | Overflow interrupt request |
| hi_ovf_set | output | 1 | Split-mode high counter wrap pulse toward the neighbour timer |

## Verification
The in-line properties check, on every cycle, the local rules: the reload from the high register and its hold in mode 10, the untouched upper prescaler bits in mode 00, write priority on the low register, the flag set and acknowledge ordering, the frozen low register when stopped or gated, and the half-rate tick spacing. The exact count sequences, the carry between prescaler and high register, the 16-bit wrap point, the edge detection through synchronizers and the split high counter's wrap pulse are shown only by the bench. It compares a behavioural model against every read address, `irq` and `hi_ovf_set` on every clock while scenarios step through each mode, gate pattern, clock source and write collision.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MD_PRESCALE = 2'b00,
    MD_WIDE     = 2'b01,
    MD_RELOAD   = 2'b10,
    MD_SPLIT    = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      evt_sel;
    tmr_mode_e mode;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  localparam logic [1:0] A_LO   = 2'd0;
  localparam logic [1:0] A_HI   = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else         stage_q[g] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/tmr_tick.sv
module tmr_tick (
  input  logic clk,
  input  logic rst_ni,
  input  logic clk_sel,
  input  logic periph_tick,
  input  logic ev_s,
  output logic tick,
  output logic ev_fall
);

  logic half_q, half_d;
  logic evp_q, evp_d;
  logic evp_en;

  always_comb begin
    half_d  = ~half_q;
    tick    = clk_sel ? periph_tick : half_q;
    evp_en  = tick;
    evp_d   = ev_s;
    ev_fall = tick & evp_q & ~ev_s;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= half_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     evp_q <= 1'b0;
    else if (evp_en) evp_q <= evp_d;
  end

  // R8: the half-rate clock never ticks on two consecutive cycles
  p_half_rate_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clk_sel && tick) |=> (clk_sel || !tick));

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CW  = 8,
  parameter int PRE = 5
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  tmr_mode_e     mode,
  input  logic          low_en,
  input  logic          low_evt,
  input  logic          tick,
  input  logic          hi_run,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] lo_q,
  output logic [CW-1:0] hi_q,
  output logic          ovf_lo,
  output logic          ovf_hi
);

  localparam int DW = 2 * CW;
  localparam logic [PRE-1:0] PRE_ONE = PRE'(1);
  localparam logic [CW-1:0]  CW_ONE  = CW'(1);
  localparam logic [DW-1:0]  DW_ONE  = DW'(1);

  logic [CW-1:0] lo_d, hi_d;
  logic          lo_en, hi_en;
  logic          cnt_wr, inc_lo, inc_hi;

  always_comb begin
    cnt_wr = wr_lo | wr_hi;
    inc_lo = low_en & low_evt & ~cnt_wr;
    inc_hi = (mode == MD_SPLIT) & hi_run & tick & ~cnt_wr;
    lo_d   = lo_q;
    hi_d   = hi_q;
    ovf_lo = 1'b0;
    ovf_hi = 1'b0;
    unique case (mode)
      MD_PRESCALE: if (inc_lo) begin
        lo_d[PRE-1:0] = lo_q[PRE-1:0] + PRE_ONE;
        if (&lo_q[PRE-1:0]) begin
          hi_d   = hi_q + CW_ONE;
          ovf_lo = &hi_q;
        end
      end
      MD_WIDE: if (inc_lo) begin
        {hi_d, lo_d} = {hi_q, lo_q} + DW_ONE;
        ovf_lo       = &{hi_q, lo_q};
      end
      MD_RELOAD: if (inc_lo) begin
        if (&lo_q) begin
          lo_d   = hi_q;
          ovf_lo = 1'b1;
        end else begin
          lo_d   = lo_q + CW_ONE;
        end
      end
      MD_SPLIT: begin
        if (inc_lo) begin
          lo_d   = lo_q + CW_ONE;
          ovf_lo = &lo_q;
        end
        if (inc_hi) begin
          hi_d   = hi_q + CW_ONE;
          ovf_hi = &hi_q;
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_d = wr_data;
    if (wr_hi) hi_d = wr_data;
    lo_en = inc_lo | wr_lo;
    hi_en = inc_lo | inc_hi | wr_hi;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    lo_q <= '0;
    else if (lo_en) lo_q <= lo_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    hi_q <= '0;
    else if (hi_en) hi_q <= hi_d;
  end

  // R2: counting never alters the bits above the prescaler
  p_prefix_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == MD_PRESCALE && !wr_lo) |=> lo_q[CW-1:PRE] == $past(lo_q[CW-1:PRE]));

  // R4: a wrap in reload mode takes the high register's value
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == MD_RELOAD && low_en && low_evt && !wr_lo && !wr_hi && (&lo_q))
      |=> lo_q == $past(hi_q));

  // R4: the reload source is left alone by counting
  p_hold_hi_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == MD_RELOAD && !wr_hi) |=> hi_q == $past(hi_q));

  // R5: the split high counter moves only on borrowed run and a tick
  p_split_hi_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == MD_SPLIT && !wr_hi && !(hi_run && tick)) |=> $stable(hi_q));

  // R10: a write wins over any count in the same cycle
  p_wr_wins_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_lo |=> lo_q == $past(wr_data));

endmodule

// File: rtl/tmr_quad.sv
module tmr_quad
  import tmr_pkg::*;
#(
  parameter int CW          = 8,
  parameter int PRE         = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_sel,
  input  logic          periph_tick,
  input  logic          ev_pin,
  input  logic          gate_pin,
  input  logic          hi_run_in,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [CW-1:0] rd_data,
  input  logic          irq_ack,
  output logic          irq,
  output logic          hi_ovf_set
);

  localparam int PAD_CTRL = CW - CTRL_W;
  localparam int PAD_FLAG = CW - 2;

  logic          rst_ni;
  logic [1:0]    pins_s;
  logic          ev_s, gate_s;
  logic          tick, ev_fall;
  tmr_ctrl_t     ctrl_q, ctrl_d;
  logic          run_q, run_d, flag_q, flag_d;
  logic          ctrl_en, flag_en;
  logic          wr_lo, wr_hi, wr_ctrl, wr_flag;
  logic          low_en, low_evt;
  logic [CW-1:0] lo_q, hi_q;
  logic          ovf_lo, ovf_hi;

  tmr_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_ni(rst_n), .d(1'b1), .q(rst_ni)
  );

  tmr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_ni(rst_ni), .d({gate_pin, ev_pin}), .q(pins_s)
  );
  assign {gate_s, ev_s} = pins_s;

  tmr_tick u_tick (
    .clk(clk), .rst_ni(rst_ni), .clk_sel(clk_sel), .periph_tick(periph_tick),
    .ev_s(ev_s), .tick(tick), .ev_fall(ev_fall)
  );

  always_comb begin
    wr_lo   = wr_en && (wr_sel == A_LO);
    wr_hi   = wr_en && (wr_sel == A_HI);
    wr_ctrl = wr_en && (wr_sel == A_CTRL);
    wr_flag = wr_en && (wr_sel == A_FLAG);
    low_en  = run_q & (~ctrl_q.gate | gate_s);
    low_evt = ctrl_q.evt_sel ? ev_fall : tick;
  end

  tmr_core #(.CW(CW), .PRE(PRE)) u_core (
    .clk(clk), .rst_ni(rst_ni), .mode(ctrl_q.mode), .low_en(low_en),
    .low_evt(low_evt), .tick(tick), .hi_run(hi_run_in), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .wr_data(wr_data), .lo_q(lo_q), .hi_q(hi_q),
    .ovf_lo(ovf_lo), .ovf_hi(ovf_hi)
  );

  always_comb begin
    ctrl_en = wr_ctrl;
    ctrl_d  = tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
    run_d   = wr_flag ? wr_data[0] : run_q;
    if (wr_flag)      flag_d = wr_data[1];
    else if (ovf_lo)  flag_d = 1'b1;
    else if (irq_ack) flag_d = 1'b0;
    else              flag_d = flag_q;
    flag_en = wr_flag | ovf_lo | irq_ack;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (flag_en) begin
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    unique case (rd_sel)
      A_LO:    rd_data = lo_q;
      A_HI:    rd_data = hi_q;
      A_CTRL:  rd_data = {{PAD_CTRL{1'b0}}, ctrl_q};
      default: rd_data = {{PAD_FLAG{1'b0}}, flag_q, run_q};
    endcase
    irq        = flag_q;
    hi_ovf_set = ovf_hi;
  end

  // R6: a rollover without a competing flag write raises the flag
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (ovf_lo && !wr_flag) |=> irq);

  // R6: acknowledge clears the flag when nothing else claims it
  p_ack_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq && irq_ack && !ovf_lo && !wr_flag) |=> !irq);

  // R7: a stopped timer holds its low count
  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run_q && !wr_lo) |=> $stable(lo_q));

  // R7: a closed gate holds the low count
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_q.gate && !gate_s && !wr_lo) |=> $stable(lo_q));

endmodule

// File: tb/tmr_quad_test.sv
module tmr_quad_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clk_sel, periph_tick, ev_pin, gate_pin, hi_run_in;
  logic       wr_en, irq_ack;
  logic [1:0] wr_sel, rd_sel;
  logic [7:0] wr_data, rd_data;
  logic       irq, hi_ovf_set;

  always #5 clk = ~clk;

  tmr_quad uut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .periph_tick(periph_tick),
    .ev_pin(ev_pin), .gate_pin(gate_pin), .hi_run_in(hi_run_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_ack(irq_ack), .irq(irq), .hi_ovf_set(hi_ovf_set)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_lo, m_hi, m_ctrl, m_run, m_flag;
  int m_half, m_evm, m_evs, m_gm, m_gs, m_evp, m_rc;

  task automatic m_clear();
    m_lo = 0; m_hi = 0; m_ctrl = 0; m_run = 0; m_flag = 0;
    m_half = 0; m_evm = 0; m_evs = 0; m_gm = 0; m_gs = 0; m_evp = 0;
  endtask

  function automatic int cur_tick();
    return clk_sel ? int'(periph_tick) : m_half;
  endfunction

  function automatic int cnt_write();
    return (wr_en && (wr_sel == 2'd0 || wr_sel == 2'd1)) ? 1 : 0;
  endfunction

  task automatic m_step();
    int tk, fall, cw, gate, src, md, len, inc, hinc, nlo, nhi, ov, ovh;
    tk   = cur_tick();
    fall = (tk != 0 && m_evp != 0 && m_evs == 0) ? 1 : 0;
    cw   = cnt_write();
    gate = (m_ctrl >> 3) & 1;
    src  = (m_ctrl >> 2) & 1;
    md   = m_ctrl & 3;
    len  = (m_run != 0 && (gate == 0 || m_gs != 0)) ? 1 : 0;
    inc  = (len != 0 && (src != 0 ? fall : tk) != 0 && cw == 0) ? 1 : 0;
    hinc = (md == 3 && hi_run_in && tk != 0 && cw == 0) ? 1 : 0;
    nlo = m_lo; nhi = m_hi; ov = 0; ovh = 0;
    if (inc != 0) begin
      case (md)
        0: begin
          if ((m_lo % 32) == 31) begin
            nlo = m_lo - 31;
            nhi = (m_hi + 1) % 256;
            ov  = (m_hi == 255) ? 1 : 0;
          end else nlo = m_lo + 1;
        end
        1: begin
          int w;
          w   = m_hi * 256 + m_lo + 1;
          ov  = (w == 65536) ? 1 : 0;
          w   = w % 65536;
          nhi = w / 256;
          nlo = w % 256;
        end
        2: begin
          if (m_lo == 255) begin nlo = m_hi; ov = 1; end
          else nlo = m_lo + 1;
        end
        default: begin
          nlo = (m_lo + 1) % 256;
          ov  = (m_lo == 255) ? 1 : 0;
        end
      endcase
    end
    if (hinc != 0) nhi = (m_hi + 1) % 256;
    if (wr_en && wr_sel == 2'd0) nlo = int'(wr_data);
    if (wr_en && wr_sel == 2'd1) nhi = int'(wr_data);
    if (wr_en && wr_sel == 2'd2) m_ctrl = int'(wr_data) % 16;
    if (wr_en && wr_sel == 2'd3) begin
      m_run  = int'(wr_data[0]);
      m_flag = int'(wr_data[1]);
    end else if (ov != 0) m_flag = 1;
    else if (irq_ack) m_flag = 0;
    m_lo = nlo; m_hi = nhi;
    if (tk != 0) m_evp = m_evs;
    m_evs = m_evm; m_evm = int'(ev_pin);
    m_gs  = m_gm;  m_gm  = int'(gate_pin);
    m_half = 1 - m_half;
    ovh = ovh;
  endtask

  task automatic check(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    int exp_rd, exp_h;
    case (rd_sel)
      2'd0: exp_rd = m_lo;
      2'd1: exp_rd = m_hi;
      2'd2: exp_rd = m_ctrl;
      default: exp_rd = m_flag * 2 + m_run;
    endcase
    exp_h = ((m_ctrl & 3) == 3 && hi_run_in && cur_tick() != 0 && m_hi == 255 &&
             cnt_write() == 0 && m_rc >= 2) ? 1 : 0;
    check($sformatf("rd_data[sel=%0d]", rd_sel), int'(rd_data), exp_rd);
    check("irq", int'(irq), m_flag);
    check("hi_ovf_set", int'(hi_ovf_set), exp_h);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin m_rc = 0; m_clear(); end
    else if (m_rc < 2) begin m_rc++; m_clear(); end
    else m_step();
    #3;
    if (!done) compare();
  end

  always @(negedge clk) rd_sel <= rd_sel + 2'd1;

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; rd_sel = 2'd0;
    clk_sel = 1'b1; periph_tick = 1'b1; ev_pin = 1'b1; gate_pin = 1'b0;
    hi_run_in = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'h00; irq_ack = 1'b0;
    idle(3);
    rst_n = 1'b1;
    // R1: reset values on every read address
    cur_req = "R1";
    idle(8);

    // R11: register map read-back
    cur_req = "R11";
    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'h0E); idle(4);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00); idle(4);

    // R3: 16-bit wrap, then R6 acknowledge
    cur_req = "R3";
    wr(2'd0, 8'hF0); wr(2'd1, 8'hFF); wr(2'd2, 8'h01); wr(2'd3, 8'h01); idle(30);
    cur_req = "R6";
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0; idle(4);

    // R2: prescaler with upper bits set
    cur_req = "R2";
    wr(2'd3, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'hE0); wr(2'd1, 8'hFE);
    wr(2'd3, 8'h01); idle(80); wr(2'd3, 8'h00);

    // R8: half-rate clock then sparse peripheral ticks
    cur_req = "R8";
    clk_sel = 1'b0;
    wr(2'd2, 8'h01); wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd3, 8'h01); idle(21);
    clk_sel = 1'b1;
    for (int i = 0; i < 30; i++) begin @(negedge clk); periph_tick = 1'($urandom % 2); end
    periph_tick = 1'b1; wr(2'd3, 8'h00);

    // R4: auto-reload
    cur_req = "R4";
    wr(2'd2, 8'h02); wr(2'd1, 8'hF8); wr(2'd0, 8'hFC); wr(2'd3, 8'h01); idle(30);
    wr(2'd3, 8'h00);

    // R5: split counters
    cur_req = "R5";
    wr(2'd2, 8'h03); wr(2'd0, 8'hF0); wr(2'd1, 8'hF5);
    hi_run_in = 1'b1; wr(2'd3, 8'h01); idle(30);
    hi_run_in = 1'b0; idle(5); wr(2'd3, 8'h00);
    wr(2'd1, 8'hFA); hi_run_in = 1'b1; idle(12); hi_run_in = 1'b0; idle(3);

    // R7: gated counting
    cur_req = "R7";
    wr(2'd2, 8'h09); wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd3, 8'h01);
    for (int i = 0; i < 40; i++) begin @(negedge clk); gate_pin = 1'((i / 5) % 2); end
    gate_pin = 1'b0; idle(4); wr(2'd3, 8'h00);

    // R9: event counting on falling edges
    cur_req = "R9";
    wr(2'd2, 8'h05); wr(2'd0, 8'hFD); wr(2'd1, 8'hFF); wr(2'd3, 8'h01);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); ev_pin = 1'((i / 3) % 2); periph_tick = 1'($urandom % 2);
    end
    clk_sel = 1'b0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); ev_pin = 1'((i / 4) % 2); end
    clk_sel = 1'b1; periph_tick = 1'b1; ev_pin = 1'b1; idle(4); wr(2'd3, 8'h00);

    // R10: writes colliding with counting and with overflow
    cur_req = "R10";
    wr(2'd2, 8'h01); wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd3, 8'h01);
    for (int i = 0; i < 6; i++) begin wr(2'd0, 8'(i * 7)); idle(1); end
    wr(2'd1, 8'hFF); wr(2'd0, 8'hFE); wr(2'd3, 8'h01); wr(2'd3, 8'h01); idle(3);
    wr(2'd1, 8'hFF); wr(2'd0, 8'hFF);
    irq_ack = 1'b1; idle(3); irq_ack = 1'b0; idle(3);
    wr(2'd3, 8'h00);

    // R6: flag written directly, then acknowledged
    cur_req = "R6";
    wr(2'd3, 8'h02); idle(3);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0; idle(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule